// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Stop-Bit Check

This block is the receive half of a classic microcontroller serial port. It watches a single serial input line, finds the falling edge of a start bit, samples each bit near its centre using a 16x oversampling tick, and assembles either an 8-bit frame or a 9-bit frame. Software controls it through two byte-wide registers: a serial control register and a power-control register. Both sit on a simple select/write/read port.

Setting a check-enable bit in the power-control register turns on stop-bit checking. While checking is on, bit 7 of the control register no longer reaches the mode-select flop. Reads and writes of that bit go to a sticky framing-error flag instead. Both values are held at all times, and the enable chooses which one the bus sees. Checking also changes when the receive flag rises. With checking off, the flag rises at the last data bit. With checking on, it rises at the stop bit, so software sees the error flag already settled when it services the frame.

The baud tick comes from outside the block. The serial line passes through a two-flop synchronizer before the block uses it.

Top module: `serial_rx_chk`

## Requirements
- R1: In 8-bit mode (control bits 7:6 = 01), a frame is one low start bit, eight data bits sent least-significant first, and one stop bit. The received byte appears on `rx_byte`.
- R2: In idle, a low level on the line starts a frame. If the start bit votes high at mid-bit, the frame is abandoned: nothing is received and the receive flag stays clear.
- R3: Each bit's value is the majority of the line samples taken at oversampling ticks 7, 8 and 9 of that bit. A single disturbed sample does not change the received bit.
- R4: In the 9-bit modes (control bits 7:6 = 10 or 11), eight data bits and then a ninth bit are received. The ninth bit is stored in control bit 2.
- R5: In 8-bit mode, the sampled stop-bit value is stored in control bit 2.
- R6: No frame is received while the receive-enable bit (control bit 4) is 0, or while control bits 7:6 are 00.
- R7: Power-control bit 6 is the check enable. When it is 1, control bit 7 reads and writes the framing-error flag. When it is 0, control bit 7 reads and writes the mode bit. Each value is kept while the other is selected.
- R8: With checking on, a stop bit sampled as 0 sets the framing-error flag.
- R9: Once set, the framing-error flag stays set through later frames that have valid stop bits. Only a software write of 0 or reset clears it.
- R10: With checking off, a stop bit sampled as 0 leaves the framing-error flag unchanged.
- R11: With checking off, the receive flag (control bit 0) rises at mid-point of the last data bit: bit 8 in 8-bit mode, the ninth bit in 9-bit modes. With checking on, it rises at mid-point of the stop bit.
- R12: The receive flag stays set until software writes 0 to control bit 0.
- R13: After reset, both registers read 0, `rx_byte` is 0 and `rx_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd_in | input | 1 | Serial receive line, idle high |
| reg_sel | input | 1 | Register select: 0 = serial control, 1 = power control |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| rx_byte | output | DATA_W | Last received data byte |
| rx_ready | output | 1 | Receive flag (control bit 0) |

## Verification
The hardest state to reach is a framing-error flag that stays set while later frames with good stop bits arrive. Reaching it needs a bad frame with checking on, then a receive-flag clear that writes 1 back into bit 7, then a clean frame. Directed sequences build exactly that chain of register writes and frames. They also probe the receive flag a few cycles into the stop bit, which pins down the flag timing for each checking setting. Random frames then mix modes, check enables, ninth bits and bad stop bits.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} rx_state_t;

  typedef struct packed {
    logic last_data;
    logic ninth;
    logic stop;
    logic nine;
    logic val;
  } rx_evt_t;

  localparam int C_MODE_LO = 6;
  localparam int C_RXEN    = 4;
  localparam int C_RX9     = 2;
  localparam int C_RXF     = 0;
  localparam int P_CHK     = 6;
endpackage

// File: rtl/srx_vote.sv
module srx_vote (
  input  logic [2:0] smp,
  output logic       maj
);
  assign maj = (smp[0] & smp[1]) | (smp[0] & smp[2]) | (smp[1] & smp[2]);
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd,
  input  logic              en,
  input  logic              nine_req,
  output rx_evt_t           evt,
  output logic [DATA_W-1:0] data_q
);
  localparam int SW  = $clog2(OSR);
  localparam int MID = OSR / 2;
  localparam int BW  = $clog2(DATA_W + 3);

  rx_state_t         state;
  logic [SW-1:0]     sub;
  logic [BW-1:0]     bitn;
  logic [1:0]        win;
  logic              nine;
  logic [DATA_W-1:0] shreg;
  logic              vote;
  logic              at_vote;
  logic [BW-1:0]     stop_idx;
  logic [BW-1:0]     last_idx;

  srx_vote vote_i (.smp({rxd, win}), .maj(vote));

  assign at_vote  = tick && (state == ST_RUN) && (sub == SW'(MID + 1));
  assign stop_idx = nine ? BW'(DATA_W + 2) : BW'(DATA_W + 1);
  assign last_idx = nine ? BW'(DATA_W + 1) : BW'(DATA_W);

  always_comb begin
    evt.last_data = at_vote && (bitn == last_idx);
    evt.ninth     = at_vote && nine && (bitn == BW'(DATA_W + 1));
    evt.stop      = at_vote && (bitn == stop_idx);
    evt.nine      = nine;
    evt.val       = vote;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      sub    <= '0;
      bitn   <= '0;
      win    <= '0;
      nine   <= 1'b0;
      shreg  <= '0;
      data_q <= '0;
    end else if (tick) begin
      if (state == ST_IDLE) begin
        if (en && !rxd) begin
          state <= ST_RUN;
          sub   <= SW'(1);
          bitn  <= '0;
          nine  <= nine_req;
        end
      end else begin
        if (sub == SW'(MID - 1)) win[0] <= rxd;
        if (sub == SW'(MID))     win[1] <= rxd;
        if (sub == SW'(MID + 1)) begin
          if (bitn == '0 && vote) state <= ST_IDLE;
          if (bitn != '0 && bitn <= BW'(DATA_W))
            shreg <= {vote, shreg[DATA_W-1:1]};
          if (bitn == BW'(DATA_W))
            data_q <= {vote, shreg[DATA_W-1:1]};
          if (bitn == stop_idx) state <= ST_IDLE;
        end
        if (sub == SW'(OSR - 1)) begin
          sub  <= '0;
          bitn <= bitn + 1'b1;
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end

  // R2
  false_start_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && tick && rxd) |=> (state == ST_IDLE));

  // R6
  rx_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !en) |=> (state == ST_IDLE));
endmodule

// File: rtl/srx_regs.sv
module srx_regs
  import srx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic       sel,
  input  logic [7:0] wdata,
  input  rx_evt_t    evt,
  output logic [7:0] rdata,
  output logic       rx_go,
  output logic       nine_req,
  output logic       ri
);
  logic       sm0;
  logic       fe;
  logic [6:0] ctl_lo;
  logic [7:0] pcon;
  logic       chk;
  logic       wr_ctl;
  logic       wr_pc;

  assign chk      = pcon[P_CHK];
  assign wr_ctl   = wr && !sel;
  assign wr_pc    = wr && sel;
  assign rdata    = sel ? pcon : {(chk ? fe : sm0), ctl_lo};
  assign nine_req = sm0;
  assign rx_go    = ctl_lo[C_RXEN] && (sm0 || ctl_lo[C_MODE_LO]);
  assign ri       = ctl_lo[C_RXF];

  always_ff @(posedge clk) begin
    if (rst) begin
      sm0    <= 1'b0;
      fe     <= 1'b0;
      ctl_lo <= '0;
      pcon   <= '0;
    end else begin
      if (wr_pc) pcon <= wdata;
      if (wr_ctl) begin
        ctl_lo <= wdata[6:0];
        if (chk) fe  <= wdata[7];
        else     sm0 <= wdata[7];
      end
      if ((evt.last_data && !chk) || (evt.stop && chk)) ctl_lo[C_RXF] <= 1'b1;
      if (evt.ninth)               ctl_lo[C_RX9] <= evt.val;
      if (evt.stop && !evt.nine)   ctl_lo[C_RX9] <= evt.val;
      if (evt.stop && chk && !evt.val) fe <= 1'b1;
    end
  end

  // R8
  fe_set_chk: assert property (@(posedge clk) disable iff (rst)
    (evt.stop && chk && !evt.val) |=> fe);

  // R9
  fe_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (fe && !(wr_ctl && chk)) |=> fe);

  // R10
  fe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!chk && !wr_ctl) |=> $stable(fe));

  // R7
  mode_kept_chk: assert property (@(posedge clk) disable iff (rst)
    chk |=> $stable(sm0));

  // R12
  ri_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_lo[C_RXF] && !wr_ctl) |=> ctl_lo[C_RXF]);
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk
  import srx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              rxd_in,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_ready
);
  logic [SYNC_N-1:0] sync_q;
  logic              rx_go;
  logic              nine_req;
  rx_evt_t           evt;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_N-2:0], rxd_in};
  end

  srx_framer #(.DATA_W(DATA_W), .OSR(OSR)) framer_i (
    .clk(clk), .rst(rst), .tick(baud_tick), .rxd(sync_q[SYNC_N-1]),
    .en(rx_go), .nine_req(nine_req), .evt(evt), .data_q(rx_byte)
  );

  srx_regs regs_i (
    .clk(clk), .rst(rst), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .evt(evt), .rdata(reg_rdata), .rx_go(rx_go), .nine_req(nine_req),
    .ri(rx_ready)
  );
endmodule

// File: tb/serial_rx_chk_tb_top.sv
module serial_rx_chk_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       rxd_in = 1'b1;
  logic       reg_sel = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [7:0] rx_byte;
  logic       rx_ready;

  int checks = 0;
  int fails = 0;
  int tcnt = 0;
  logic early;
  logic [7:0] rv;

  serial_rx_chk dut_i (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .rxd_in(rxd_in),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rx_byte(rx_byte), .rx_ready(rx_ready)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 4;
    baud_tick = (tcnt == 3);
  end

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_ctl(input logic b7, input logic mlo,
                                         input logic ren, input logic rb8, input logic ri);
    return {b7, mlo, 1'b0, ren, 1'b0, rb8, 1'b0, ri};
  endfunction

  task automatic wr_reg(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic sel, output logic [7:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic drive_bit(input logic v, input logic glitch);
    rxd_in = v;
    if (glitch) begin
      repeat (32) @(negedge clk);
      rxd_in = ~v;
      repeat (4) @(negedge clk);
      rxd_in = v;
      repeat (28) @(negedge clk);
    end else begin
      repeat (64) @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input logic nine, input logic b9,
                            input logic stopv, input int gbit, output logic er);
    @(negedge clk);
    drive_bit(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i], gbit == i);
    if (nine) drive_bit(b9, 1'b0);
    rxd_in = stopv;
    repeat (8) @(negedge clk);
    er = rx_ready;
    repeat (56) @(negedge clk);
    rxd_in = 1'b1;
    repeat (80) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R13 reset state
    rd_reg(1'b0, rv); check("R13 ctl", rv, 8'h00);
    rd_reg(1'b1, rv); check("R13 pcon", rv, 8'h00);
    check("R13 byte", rx_byte, 8'h00);
    check("R13 ri", {7'b0, rx_ready}, 8'h00);

    // R7 shared bit 7
    wr_reg(1'b0, 8'h90);
    rd_reg(1'b0, rv); check("R7 sm0 set", rv, 8'h90);
    wr_reg(1'b1, 8'h40);
    rd_reg(1'b0, rv); check("R7 fe view", rv, 8'h10);
    wr_reg(1'b0, 8'h90);
    rd_reg(1'b0, rv); check("R7 fe write", rv, 8'h90);
    wr_reg(1'b1, 8'h00);
    rd_reg(1'b0, rv); check("R7 sm0 kept", rv, 8'h90);
    wr_reg(1'b1, 8'h40);
    wr_reg(1'b0, 8'h10);
    rd_reg(1'b0, rv); check("R9 sw clear", rv, 8'h10);

    // R1 R5 R11 mode 1 without check
    wr_reg(1'b1, 8'h00);
    wr_reg(1'b0, 8'h50);
    send_frame(8'hA5, 1'b0, 1'b0, 1'b1, -1, early);
    check("R1 byte", rx_byte, 8'hA5);
    check("R11 early ri off", {7'b0, early}, 8'h01);
    rd_reg(1'b0, rv); check("R5 rb8 stop", rv, exp_ctl(0, 1, 1, 1, 1));

    // R2 false start then real frame
    wr_reg(1'b0, 8'h50);
    @(negedge clk); rxd_in = 1'b0;
    repeat (12) @(negedge clk); rxd_in = 1'b1;
    repeat (200) @(negedge clk);
    check("R2 no ri", {7'b0, rx_ready}, 8'h00);
    check("R2 byte kept", rx_byte, 8'hA5);
    send_frame(8'h3C, 1'b0, 1'b0, 1'b1, -1, early);
    check("R2 after", rx_byte, 8'h3C);

    // R3 one disturbed sample
    wr_reg(1'b0, 8'h50);
    send_frame(8'h0F, 1'b0, 1'b0, 1'b1, 0, early);
    check("R3 glitch bit0", rx_byte, 8'h0F);
    send_frame(8'h0F, 1'b0, 1'b0, 1'b1, 5, early);
    check("R3 glitch bit5", rx_byte, 8'h0F);

    // R6 disabled reception
    wr_reg(1'b0, 8'h40);
    send_frame(8'h55, 1'b0, 1'b0, 1'b1, -1, early);
    check("R6 ren0 ri", {7'b0, rx_ready}, 8'h00);
    check("R6 ren0 byte", rx_byte, 8'h0F);
    wr_reg(1'b0, 8'h10);
    send_frame(8'h55, 1'b0, 1'b0, 1'b1, -1, early);
    check("R6 mode0 ri", {7'b0, rx_ready}, 8'h00);
    check("R6 mode0 byte", rx_byte, 8'h0F);

    // R8 R9 R11 check on
    wr_reg(1'b0, 8'h50);
    wr_reg(1'b1, 8'h40);
    wr_reg(1'b0, 8'h50);
    send_frame(8'h99, 1'b0, 1'b0, 1'b0, -1, early);
    check("R11 early ri on", {7'b0, early}, 8'h00);
    rd_reg(1'b0, rv); check("R8 fe set", rv, exp_ctl(1, 1, 1, 0, 1));
    wr_reg(1'b0, 8'hD0);
    send_frame(8'h66, 1'b0, 1'b0, 1'b1, -1, early);
    rd_reg(1'b0, rv); check("R9 fe sticky", rv, exp_ctl(1, 1, 1, 1, 1));
    check("R1 byte on", rx_byte, 8'h66);
    wr_reg(1'b0, 8'h50);
    rd_reg(1'b0, rv); check("R9 fe cleared", rv, 8'h50);

    // R10 bad stop with check off
    wr_reg(1'b1, 8'h00);
    wr_reg(1'b0, 8'h50);
    send_frame(8'h12, 1'b0, 1'b0, 1'b0, -1, early);
    wr_reg(1'b1, 8'h40);
    rd_reg(1'b0, rv); check("R10 no fe", rv, exp_ctl(0, 1, 1, 0, 1));

    // R12 flag held, then cleared
    repeat (300) @(negedge clk);
    check("R12 held", {7'b0, rx_ready}, 8'h01);
    wr_reg(1'b0, 8'h50);
    #1 check("R12 cleared", {7'b0, rx_ready}, 8'h00);

    // R4 9-bit modes
    wr_reg(1'b1, 8'h00);
    wr_reg(1'b0, 8'hD0);
    send_frame(8'h81, 1'b1, 1'b1, 1'b1, -1, early);
    check("R4 m3 byte", rx_byte, 8'h81);
    check("R11 early ninth", {7'b0, early}, 8'h01);
    rd_reg(1'b0, rv); check("R4 m3 rb8", rv, exp_ctl(1, 1, 1, 1, 1));
    wr_reg(1'b0, 8'h90);
    send_frame(8'h7E, 1'b1, 1'b0, 1'b1, -1, early);
    check("R4 m2 byte", rx_byte, 8'h7E);
    rd_reg(1'b0, rv); check("R4 m2 rb8", rv, exp_ctl(1, 0, 1, 0, 1));

    // random frames
    rv = 8'($urandom(32'd4242));
    for (int n = 0; n < 14; n++) begin
      logic [1:0] md;
      logic ck, b9, sv, nn, rb;
      logic [7:0] d;
      md = 2'($urandom_range(3, 1));
      ck = 1'($urandom());
      b9 = 1'($urandom());
      sv = ($urandom_range(3, 0) != 0);
      d  = 8'($urandom());
      nn = md[1];
      rb = nn ? b9 : sv;
      wr_reg(1'b1, 8'h00);
      wr_reg(1'b0, {md, 6'b010000});
      wr_reg(1'b1, {1'b0, ck, 6'b0});
      if (ck) wr_reg(1'b0, {1'b0, md[0], 6'b010000});
      send_frame(d, nn, b9, sv, -1, early);
      check("R1 R4 rand byte", rx_byte, d);
      check("R11 rand early", {7'b0, early}, {7'b0, !ck});
      rd_reg(1'b0, rv);
      check("R5 R8 rand ctl", rv, exp_ctl(ck ? (!sv) : md[1], md[0], 1, rb, 1));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule